// File: doc/BRIEF.md
# Tagged Entry Packer and Unpacker

This block sits between a 32-bit register port and a serial bus engine. Toward the engine, software writes 32-bit words. Each word carries one or two 16-bit tagged entries, where a tag sits above one data byte. The block queues those entries and hands them to the engine one at a time over a valid/ready stream. Toward software, the block collects the bytes the engine receives and returns them packed two to a 32-bit read word. Each byte sits in the low byte of its own 16-bit half.

A small configuration port sets the operating mode and the two transfer counts. Software programs the number of entries to send, which includes the start entry, and the number of bytes to receive. The block reports when each count has been reached. It also raises a service flag, either only at the end of the transfer (FIFO mode) or after every block of entries (block mode), so software knows when to refill or drain. Queue capacities come from block-size and FIFO-size codes given as parameters. Because every entry carries a tag beside its byte, the usable data capacity is half the raw word count.

Top module: `tag_pack_path`

## Requirements
- R1: With unpacking enabled (mode bit 14 set), an accepted write whose bits [31:16] are nonzero yields two entries: bits [15:0] first, then bits [31:16].
- R2: With unpacking enabled, a write whose bits [31:16] are zero is a lone trailing entry and yields exactly one entry, taken from bits [15:0].
- R3: With unpacking disabled, every accepted write yields exactly one entry from bits [15:0], whatever the upper half holds.
- R4: The output queue holds blk*(2<<n)/2 entries, where block code 0, 1 or 2 means 4, 16 or 32 words. `out_full` is high while fewer than two slots are free. A write whose entries do not fit is dropped whole and sets the sticky `out_ovf`, which clears only when a new output count is loaded.
- R5: Configuration select 1 loads the output count and clears the output progress, done, service and overflow state. Each entry consumed by the engine advances the progress. When the progress reaches a nonzero count, `out_done` and `out_svc` rise together, and `out_done` holds until the next load. A count of zero never completes.
- R6: In block mode (mode bit 10 for output, bit 12 for input), the matching service flag also rises after every blk/2 entries or bytes. In FIFO mode it rises only at done. An acknowledge pulse clears a service flag, but not `done`.
- R7: With packing enabled (mode bit 15), a read word holds the first received byte in bits [7:0] and the second in bits [23:16], with all other bits zero.
- R8: With packing enabled, a single leftover byte is not offered for reading until the input count is done. Once offered, it reads back in bits [7:0] with the upper bits zero.
- R9: With packing disabled, every read word carries one byte in bits [7:0] and zero above it.
- R10: A received byte that arrives while the input queue is full is dropped and sets the sticky `in_ovf`, which clears when a new input count is loaded (select 2).
- R11: Each accepted received byte advances the input progress. When it reaches a nonzero input count, `in_done` and `in_svc` rise together.
- R12: While `ent_valid` is high and `ent_ready` is low, the entry stays offered with unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 mode, 1 output count, 2 input count, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| wr_valid | input | 1 | Output port word write |
| wr_data | input | 32 | Output port word, one or two entries |
| out_full | output | 1 | Fewer than two output slots free |
| ent_valid | output | 1 | Entry offered to the bus engine |
| ent_data | output | 16 | Offered tagged entry |
| ent_ready | input | 1 | Bus engine takes the entry |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_en | input | 1 | Read port word pop |
| rd_data | output | 32 | Packed read word |
| in_not_empty | output | 1 | A read word is available |
| out_done | output | 1 | Output count reached |
| in_done | output | 1 | Input count reached |
| out_svc | output | 1 | Output service request |
| in_svc | output | 1 | Input service request |
| out_svc_ack | input | 1 | Clears out_svc |
| in_svc_ack | input | 1 | Clears in_svc |
| out_ovf | output | 1 | Sticky dropped output write |
| in_ovf | output | 1 | Sticky dropped received byte |

## Verification
The hardest state to reach from the ports is a packed input queue that holds one byte nobody may read yet. The bench gets there by loading an odd input count, sending three bytes, and reading out the first pair. The trailing byte only becomes visible because the count has completed. A second scenario with a zero count and a single byte shows the opposite case, where that byte stays hidden. The output queue is filled to the brim while the engine stalls, so that pair writes and lone writes both meet a full queue and must be dropped.

// File: rtl/tagpk_pkg.sv
package tagpk_pkg;
   localparam int PACK_BIT    = 15;
   localparam int UNPACK_BIT  = 14;
   localparam int IN_BLK_BIT  = 12;
   localparam int OUT_BLK_BIT = 10;

   typedef enum logic [1:0] {
      SEL_MODE    = 2'd0,
      SEL_OUT_CNT = 2'd1,
      SEL_IN_CNT  = 2'd2,
      SEL_NONE    = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic pack;
      logic unpack;
      logic in_blk;
      logic out_blk;
   } mode_t;

   function automatic int blk_words(input int code);
      case (code)
         0:       return 4;
         1:       return 16;
         default: return 32;
      endcase
   endfunction

   // raw words of the queue, halved because a tag rides with every byte
   function automatic int queue_entries(input int code, input int n);
      return blk_words(code) * (2 << n) / 2;
   endfunction

   function automatic int svc_block(input int code);
      return blk_words(code) / 2;
   endfunction

   function automatic mode_t decode_mode(input logic [15:0] m);
      mode_t d;
      d.pack    = m[PACK_BIT];
      d.unpack  = m[UNPACK_BIT];
      d.in_blk  = m[IN_BLK_BIT];
      d.out_blk = m[OUT_BLK_BIT];
      return d;
   endfunction
endpackage

// File: rtl/tagpk_ring.sv
module tagpk_ring #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    push_n,
   input  logic [W-1:0]  push_d0,
   input  logic [W-1:0]  push_d1,
   input  logic [1:0]    pop_n,
   output logic [W-1:0]  head0,
   output logic [W-1:0]  head1,
   output logic [LW-1:0] level
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("tagpk_ring: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [AW-1:0] wr_q, rd_q, wr_nx1, rd_nx1;
   logic [LW-1:0] level_q;
   logic [W-1:0]  slot_v [DEPTH];

   assign wr_nx1 = wr_q + AW'(1);
   assign rd_nx1 = rd_q + AW'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (push_n != 2'd0 && wr_q == AW'(i))
            slot_q <= push_d0;
         else if (push_n == 2'd2 && wr_nx1 == AW'(i))
            slot_q <= push_d1;
      end
      assign slot_v[i] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_q <= '0;
      end else begin
         wr_q    <= wr_q + AW'(push_n);
         rd_q    <= rd_q + AW'(pop_n);
         level_q <= level_q + LW'(push_n) - LW'(pop_n);
      end
   end

   assign head0 = slot_v[rd_q];
   assign head1 = slot_v[rd_nx1];
   assign level = level_q;
endmodule

// File: rtl/tagpk_xfer_count.sv
module tagpk_xfer_count #(
   parameter int CW  = 9,
   parameter int BLK = 2,
   localparam int BW = $clog2(BLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          blk_mode,
   input  logic          svc_ack,
   output logic          done,
   output logic          svc
);
   generate
      if (BLK < 2 || (1 << BW) != BLK) begin : g_bad_blk
         $error("tagpk_xfer_count: BLK must be a power of two of at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q, tgt_q, cnt_nx;
   logic          done_q, svc_q;
   logic          hit_end, hit_blk;

   assign cnt_nx  = cnt_q + CW'(1);
   assign hit_end = (tgt_q != '0) && (cnt_nx == tgt_q);
   assign hit_blk = blk_mode && (cnt_nx[BW-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tgt_q  <= '0;
         done_q <= 1'b0;
         svc_q  <= 1'b0;
      end else if (load) begin
         cnt_q  <= '0;
         tgt_q  <= load_val;
         done_q <= 1'b0;
         svc_q  <= 1'b0;
      end else begin
         if (svc_ack)
            svc_q <= 1'b0;
         if (step && !done_q) begin
            cnt_q <= cnt_nx;
            if (hit_end) begin
               done_q <= 1'b1;
               svc_q  <= 1'b1;
            end else if (hit_blk) begin
               svc_q  <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign svc  = svc_q;
endmodule

// File: rtl/tagpk_out_split.sv
module tagpk_out_split #(
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_valid,
   input  logic [31:0] wr_data,
   input  logic        unpack,
   input  logic        ent_ready,
   output logic        ent_valid,
   output logic [15:0] ent_data,
   output logic        full,
   output logic        ovf_set,
   output logic        pop
);
   logic [LW-1:0] level, free, need;
   logic [15:0]   head1_unused;
   logic          two, fits;
   logic [1:0]    push_n;

   assign two    = unpack && (wr_data[31:16] != 16'h0);
   assign need   = two ? LW'(2) : LW'(1);
   assign free   = LW'(DEPTH) - level;
   assign fits   = free >= need;
   assign push_n = (wr_valid && fits) ? (two ? 2'd2 : 2'd1) : 2'd0;
   assign ovf_set = wr_valid && !fits;

   assign ent_valid = level != '0;
   assign pop       = ent_valid && ent_ready;
   assign full      = level > LW'(DEPTH - 2);

   tagpk_ring #(.W(16), .DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_n  (push_n),
      .push_d0 (wr_data[15:0]),
      .push_d1 (wr_data[31:16]),
      .pop_n   ({1'b0, pop}),
      .head0   (ent_data),
      .head1   (head1_unused),
      .level   (level)
   );
endmodule

// File: rtl/tagpk_in_merge.sv
module tagpk_in_merge #(
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        pack,
   input  logic        flush,
   input  logic        rd_en,
   output logic [31:0] rd_data,
   output logic        not_empty,
   output logic        ovf_set,
   output logic        accept
);
   logic [LW-1:0] level;
   logic [7:0]    b0, b1;
   logic          pair, single;
   logic [1:0]    pop_n;

   assign accept  = rx_valid && (level != LW'(DEPTH));
   assign ovf_set = rx_valid && (level == LW'(DEPTH));

   assign pair   = pack && (level >= LW'(2));
   assign single = (level != '0) && (!pack || (level == LW'(1) && flush));
   assign not_empty = pair || single;

   always_comb begin
      rd_data = 32'h0;
      if (pair)
         rd_data = {8'h0, b1, 8'h0, b0};
      else if (single)
         rd_data = {24'h0, b0};
   end

   assign pop_n = (rd_en && not_empty) ? (pair ? 2'd2 : 2'd1) : 2'd0;

   tagpk_ring #(.W(8), .DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_n  ({1'b0, accept}),
      .push_d0 (rx_byte),
      .push_d1 (8'h0),
      .pop_n   (pop_n),
      .head0   (b0),
      .head1   (b1),
      .level   (level)
   );
endmodule

// File: rtl/tag_pack_path.sv
module tag_pack_path
   import tagpk_pkg::*;
#(
   parameter int OUT_BLK_CODE  = 0,
   parameter int OUT_FIFO_CODE = 0,
   parameter int IN_BLK_CODE   = 0,
   parameter int IN_FIFO_CODE  = 0,
   parameter int CNT_W         = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        wr_valid,
   input  logic [31:0] wr_data,
   output logic        out_full,
   output logic        ent_valid,
   output logic [15:0] ent_data,
   input  logic        ent_ready,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        rd_en,
   output logic [31:0] rd_data,
   output logic        in_not_empty,
   output logic        out_done,
   output logic        in_done,
   output logic        out_svc,
   output logic        in_svc,
   input  logic        out_svc_ack,
   input  logic        in_svc_ack,
   output logic        out_ovf,
   output logic        in_ovf
);
   localparam int OUT_DEPTH = queue_entries(OUT_BLK_CODE, OUT_FIFO_CODE);
   localparam int IN_DEPTH  = queue_entries(IN_BLK_CODE, IN_FIFO_CODE);
   localparam int OUT_SVC   = svc_block(OUT_BLK_CODE);
   localparam int IN_SVC    = svc_block(IN_BLK_CODE);

   generate
      if (OUT_BLK_CODE < 0 || OUT_BLK_CODE > 2) begin : g_bad_oblk
         $error("tag_pack_path: output block code must be 0, 1 or 2");
      end
      if (IN_BLK_CODE < 0 || IN_BLK_CODE > 2) begin : g_bad_iblk
         $error("tag_pack_path: input block code must be 0, 1 or 2");
      end
      if (OUT_FIFO_CODE < 0 || OUT_FIFO_CODE > 4 || IN_FIFO_CODE < 0 || IN_FIFO_CODE > 4) begin : g_bad_fifo
         $error("tag_pack_path: FIFO size codes must be 0 to 4");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("tag_pack_path: CNT_W must be 2 to 32");
      end
   endgenerate

   logic [15:0] mode_q;
   mode_t       mode;
   logic        out_load, in_load;
   logic        out_ovf_set, in_ovf_set, ent_pop, rx_accept;
   logic        out_ovf_q, in_ovf_q;

   assign mode     = decode_mode(mode_q);
   assign out_load = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_OUT_CNT);
   assign in_load  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_IN_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= '0;
         out_ovf_q <= 1'b0;
         in_ovf_q  <= 1'b0;
      end else begin
         if (cfg_we && cfg_sel_e'(cfg_sel) == SEL_MODE)
            mode_q <= cfg_wdata[15:0];
         if (out_load)
            out_ovf_q <= 1'b0;
         if (out_ovf_set)
            out_ovf_q <= 1'b1;
         if (in_load)
            in_ovf_q <= 1'b0;
         if (in_ovf_set)
            in_ovf_q <= 1'b1;
      end
   end

   tagpk_out_split #(.DEPTH(OUT_DEPTH)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .unpack    (mode.unpack),
      .ent_ready (ent_ready),
      .ent_valid (ent_valid),
      .ent_data  (ent_data),
      .full      (out_full),
      .ovf_set   (out_ovf_set),
      .pop       (ent_pop)
   );

   tagpk_in_merge #(.DEPTH(IN_DEPTH)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .pack      (mode.pack),
      .flush     (in_done),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .not_empty (in_not_empty),
      .ovf_set   (in_ovf_set),
      .accept    (rx_accept)
   );

   tagpk_xfer_count #(.CW(CNT_W), .BLK(OUT_SVC)) u_out_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (out_load),
      .load_val (cfg_wdata[CNT_W-1:0]),
      .step     (ent_pop),
      .blk_mode (mode.out_blk),
      .svc_ack  (out_svc_ack),
      .done     (out_done),
      .svc      (out_svc)
   );

   tagpk_xfer_count #(.CW(CNT_W), .BLK(IN_SVC)) u_in_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (in_load),
      .load_val (cfg_wdata[CNT_W-1:0]),
      .step     (rx_accept),
      .blk_mode (mode.in_blk),
      .svc_ack  (in_svc_ack),
      .done     (in_done),
      .svc      (in_svc)
   );

   assign out_ovf = out_ovf_q;
   assign in_ovf  = in_ovf_q;
endmodule

// File: rtl/tag_pack_path_chk.sv
module tag_pack_path_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [1:0]  cfg_sel,
   input logic        wr_valid,
   input logic [31:0] wr_data,
   input logic        out_full,
   input logic        ent_valid,
   input logic [15:0] ent_data,
   input logic        ent_ready,
   input logic [31:0] rd_data,
   input logic        in_not_empty,
   input logic        out_done,
   input logic        in_done,
   input logic        out_svc,
   input logic        in_svc,
   input logic        out_ovf,
   input logic        unpack,
   input logic        pack
);
   // R12
   ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid && !ent_ready |=> ent_valid && $stable(ent_data));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && out_full && unpack && wr_data[31:16] != 16'h0 |=> out_ovf);

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done && !(cfg_we && cfg_sel == 2'd1) |=> out_done);

   // R5
   out_done_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_done) |-> out_svc);

   // R11
   in_done_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_done) |-> in_svc);

   // R7
   pack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_not_empty |-> rd_data[15:8] == 8'h0 && rd_data[31:24] == 8'h0);

   // R9
   nopack_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_not_empty && !pack |-> rd_data[31:8] == 24'h0);
endmodule

bind tag_pack_path tag_pack_path_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_sel      (cfg_sel),
   .wr_valid     (wr_valid),
   .wr_data      (wr_data),
   .out_full     (out_full),
   .ent_valid    (ent_valid),
   .ent_data     (ent_data),
   .ent_ready    (ent_ready),
   .rd_data      (rd_data),
   .in_not_empty (in_not_empty),
   .out_done     (out_done),
   .in_done      (in_done),
   .out_svc      (out_svc),
   .in_svc       (in_svc),
   .out_ovf      (out_ovf),
   .unpack       (mode_q[14]),
   .pack         (mode_q[15])
);

// File: tb/tag_pack_path_test.sv
`timescale 1ns/1ps
module tag_pack_path_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = 32'h0;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = 32'h0;
   logic        out_full, ent_valid;
   logic [15:0] ent_data;
   logic        ent_ready = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        in_not_empty, out_done, in_done, out_svc, in_svc;
   logic        out_svc_ack = 1'b0;
   logic        in_svc_ack = 1'b0;
   logic        out_ovf, in_ovf;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   tag_pack_path uut (.*);

   task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic put(input logic [31:0] d);
      wr_valid = 1'b1; wr_data = d;
      tick();
      wr_valid = 1'b0;
   endtask

   task automatic take(input string req, input logic [15:0] exp);
      eq(req, {31'h0, ent_valid}, 32'h1);
      eq(req, {16'h0, ent_data}, {16'h0, exp});
      ent_ready = 1'b1;
      tick();
      ent_ready = 1'b0;
   endtask

   task automatic rx(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      tick();
      rx_valid = 1'b0;
   endtask

   task automatic rd(input string req, input logic [31:0] exp);
      eq(req, {31'h0, in_not_empty}, 32'h1);
      eq(req, rd_data, exp);
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic ack_out();
      out_svc_ack = 1'b1; tick(); out_svc_ack = 1'b0;
   endtask

   task automatic ack_in();
      in_svc_ack = 1'b1; tick(); in_svc_ack = 1'b0;
   endtask

   task automatic t_reset();
      eq("R5 reset done", {30'h0, out_done, in_done}, 32'h0);
      eq("R12 reset valid", {30'h0, ent_valid, in_not_empty}, 32'h0);
      eq("R4 reset flags", {28'h0, out_full, out_ovf, in_ovf, out_svc}, 32'h0);
   endtask

   task automatic t_pair_and_lone();
      cfg(2'd0, 32'h4000);
      put(32'h0302_0101);
      take("R1 first entry low half", 16'h0101);
      take("R1 second entry high half", 16'h0302);
      eq("R1 no third entry", {31'h0, ent_valid}, 32'h0);
      put(32'h0000_0203);
      take("R2 lone entry", 16'h0203);
      eq("R2 only one entry", {31'h0, ent_valid}, 32'h0);
   endtask

   task automatic t_no_unpack();
      cfg(2'd0, 32'h0000);
      put(32'hABCD_0111);
      take("R3 low half only", 16'h0111);
      eq("R3 upper half ignored", {31'h0, ent_valid}, 32'h0);
   endtask

   task automatic t_full();
      cfg(2'd0, 32'h4000);
      cfg(2'd1, 32'h0);
      put(32'h0002_0001);
      eq("R4 not full at half", {31'h0, out_full}, 32'h0);
      put(32'h0004_0003);
      eq("R4 full", {31'h0, out_full}, 32'h1);
      eq("R4 no ovf yet", {31'h0, out_ovf}, 32'h0);
      put(32'h0006_0005);
      eq("R4 ovf on dropped pair", {31'h0, out_ovf}, 32'h1);
      put(32'h0000_0007);
      // R12 entry held while the engine stalls
      eq("R12 head held", {16'h0, ent_data}, 32'h0001);
      take("R4 drain 1", 16'h0001);
      take("R4 drain 2", 16'h0002);
      take("R4 drain 3", 16'h0003);
      take("R4 drain 4", 16'h0004);
      eq("R4 dropped writes absent", {31'h0, ent_valid}, 32'h0);
      eq("R4 ovf sticky", {31'h0, out_ovf}, 32'h1);
      cfg(2'd1, 32'h0);
      eq("R4 ovf cleared by load", {31'h0, out_ovf}, 32'h0);
   endtask

   task automatic t_out_done();
      cfg(2'd1, 32'd3);
      put(32'h0202_0201);
      put(32'h0000_0303);
      take("R5 e1", 16'h0201);
      take("R5 e2", 16'h0202);
      eq("R5 not done at 2", {30'h0, out_done, out_svc}, 32'h0);
      take("R5 e3", 16'h0303);
      eq("R5 done and svc", {30'h0, out_done, out_svc}, 32'h3);
      ack_out();
      eq("R6 ack keeps done", {30'h0, out_done, out_svc}, 32'h2);
   endtask

   task automatic t_out_block();
      cfg(2'd0, 32'h4400);
      cfg(2'd1, 32'd5);
      put(32'h0012_0011);
      put(32'h0014_0013);
      take("R6 b1", 16'h0011);
      eq("R6 no svc after 1", {31'h0, out_svc}, 32'h0);
      take("R6 b2", 16'h0012);
      eq("R6 svc after block", {31'h0, out_svc}, 32'h1);
      ack_out();
      take("R6 b3", 16'h0013);
      eq("R6 no svc after 3", {31'h0, out_svc}, 32'h0);
      take("R6 b4", 16'h0014);
      eq("R6 svc after 2nd block", {31'h0, out_svc}, 32'h1);
      ack_out();
      put(32'h0000_0015);
      take("R6 b5", 16'h0015);
      eq("R5 done in block mode", {30'h0, out_done, out_svc}, 32'h3);
   endtask

   task automatic t_pack();
      cfg(2'd0, 32'hC000);
      cfg(2'd2, 32'd0);
      rx(8'hA1);
      eq("R8 lone byte hidden", {31'h0, in_not_empty}, 32'h0);
      rx(8'hB2);
      rd("R7 packed pair", 32'h00B2_00A1);
      eq("R7 empty after read", {31'h0, in_not_empty}, 32'h0);
   endtask

   task automatic t_odd_tail();
      cfg(2'd2, 32'd3);
      rx(8'h11);
      rx(8'h22);
      eq("R11 not done at 2", {30'h0, in_done, in_svc}, 32'h0);
      rx(8'h33);
      eq("R11 done and svc", {30'h0, in_done, in_svc}, 32'h3);
      rd("R7 pair before tail", 32'h0022_0011);
      rd("R8 tail byte", 32'h0000_0033);
      eq("R8 empty after tail", {31'h0, in_not_empty}, 32'h0);
      ack_in();
   endtask

   task automatic t_no_pack();
      cfg(2'd0, 32'h4000);
      cfg(2'd2, 32'd0);
      rx(8'h44);
      rx(8'h55);
      rd("R9 one byte per word a", 32'h0000_0044);
      rd("R9 one byte per word b", 32'h0000_0055);
      eq("R9 empty", {31'h0, in_not_empty}, 32'h0);
   endtask

   task automatic t_in_ovf();
      cfg(2'd0, 32'hC000);
      cfg(2'd2, 32'd0);
      for (int i = 1; i <= 4; i++) rx(8'(i));
      eq("R10 no ovf at capacity", {31'h0, in_ovf}, 32'h0);
      rx(8'h05);
      eq("R10 ovf on fifth", {31'h0, in_ovf}, 32'h1);
      rd("R10 kept 1-2", 32'h0002_0001);
      rd("R10 kept 3-4", 32'h0004_0003);
      eq("R10 dropped byte absent", {31'h0, in_not_empty}, 32'h0);
      cfg(2'd2, 32'd0);
      eq("R10 ovf cleared by load", {31'h0, in_ovf}, 32'h0);
   endtask

   task automatic t_in_block();
      cfg(2'd0, 32'hD000);
      cfg(2'd2, 32'd6);
      rx(8'h61);
      eq("R6 in no svc after 1", {31'h0, in_svc}, 32'h0);
      rx(8'h62);
      eq("R6 in svc after block", {31'h0, in_svc}, 32'h1);
      ack_in();
      eq("R6 in svc acked", {31'h0, in_svc}, 32'h0);
      rd("R6 in data", 32'h0062_0061);
      rx(8'h63);
      eq("R6 in no svc mid block", {31'h0, in_svc}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_pair_and_lone();
      t_no_unpack();
      t_full();
      t_out_done();
      t_out_block();
      t_pack();
      t_odd_tail();
      t_no_pack();
      t_in_ovf();
      t_in_block();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule